// File: doc/BRIEF.md
# Software Interrupt Target Dispatcher

This block takes a 64-bit software write that asks for a software-generated interrupt. It decides which processing elements (PEs) of a small multi-cluster system should receive that interrupt. It then hands the targets out one at a time over a valid/ready delivery port, and each delivery carries the PE index and the 4-bit interrupt ID. The block resolves two routing modes. In targeted mode, a cluster is named by its affinity path and PEs are picked by a 16-bit target list. In broadcast mode, every PE except the writer receives the interrupt.

The decode also covers a range selector that moves the target list to a higher group of affinity-0 values. It handles the two configurations that decide whether the range selector is honoured or forces the write to be dropped. It applies a per-target permission filter to non-secure writes. Target-list bits that point at no existing PE are dropped, and a one-cycle error pulse is raised for them. Only one write is in flight at a time, and the request port is not ready until the last target has been delivered.

Top module: `sgi_dispatch`

## Requirements
- R1: Each delivery carries the interrupt ID taken from write bits [27:24]. The target list is bits [15:0], affinity level 1 is bits [23:16], level 2 is bits [39:32], level 3 is bits [55:48], the routing mode is bit 40, and the range selector RS is bits [47:44].
- R2: PE number p has the affinity tuple aff3=0, aff2=0, aff1=p/PES, aff0=p%PES. With routing mode 0, every PE is delivered whose aff3, aff2 and aff1 equal the write fields and whose aff0 equals RS*16+n for a set target-list bit n.
- R3: With routing mode 1, every PE is delivered except the one whose tuple equals the writer affinity. The writer affinity is packed as {aff3,aff2,aff1,aff0}, 8 bits each, aff3 in the top byte. The affinity fields and the target list are ignored in this mode.
- R4: In mode 0, a set target-list bit that maps to no existing PE delivers nothing. Such a bit raises err_o for exactly the one cycle after the write is accepted.
- R5: When rs_en_i is 0, RS is treated as 0.
- R6: When rs_en_i is 1, dist_rs_i is 0 and RS is non-zero, the write is dropped entirely: no delivery, no error and no busy.
- R7: When secure_i is 0 and sec_dis_i is 0, target p is delivered only if ns_allow_i[p] is 1. Secure writes, and writes made while sec_dis_i is 1, skip this filter.
- R8: Targets are delivered in ascending PE index, one per accepted delivery handshake. The index and ID are held while the handshake is stalled.
- R9: busy_o rises in the cycle after an accepted write that has at least one target, and falls after the last delivery handshake. req_ready_o is the inverse of busy_o. A write with no targets never raises busy_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Write request valid |
| req_ready_o | output | 1 | Write request accepted when high with valid |
| req_data_i | input | 64 | Write data word |
| self_aff_i | input | 32 | Writer affinity {aff3,aff2,aff1,aff0} |
| secure_i | input | 1 | Write is from the secure state |
| rs_en_i | input | 1 | Range selector supported by the CPU side |
| dist_rs_i | input | 1 | Range selector supported by the distributor |
| sec_dis_i | input | 1 | Security disabled, skip the permission filter |
| ns_allow_i | input | NC*PES | Per-target non-secure permission |
| dlv_valid_o | output | 1 | Delivery valid |
| dlv_ready_i | input | 1 | Delivery accepted |
| dlv_target_o | output | IDX_W | Target PE index |
| dlv_intid_o | output | 4 | Interrupt ID |
| busy_o | output | 1 | Dispatch in progress |
| err_o | output | 1 | Invalid target-list bit seen |

## Verification
A corrupted pending-target vector shows up at the very next delivery. It appears as a missing, duplicated or out-of-order PE index, and it can also show as busy_o staying high after the expected last handshake. A wrong decode of the range selector, the routing mode or the permission filter appears in the first delivery after the write is accepted. It can also show in the err_o level one cycle after acceptance. Stalled delivery handshakes expose any target that changes before it is taken.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  typedef struct packed {
    logic [7:0] aff3;
    logic [7:0] aff2;
    logic [7:0] aff1;
    logic [7:0] aff0;
  } aff_t;

  localparam int LIST_W  = 16;
  localparam int INTID_W = 4;
  localparam int INTID_LO = 24;
endpackage

// File: rtl/sgi_decode.sv
module sgi_decode
  import sgi_pkg::*;
#(
  parameter int NC  = 2,
  parameter int PES = 4
) (
  input  logic [63:0]        wdata_i,
  input  aff_t               self_i,
  input  logic               secure_i,
  input  logic               rs_en_i,
  input  logic               dist_rs_i,
  input  logic               sec_dis_i,
  input  logic [NC*PES-1:0]  ns_allow_i,
  output logic [NC*PES-1:0]  mask_o,
  output logic               bad_o
);
  localparam int NPE = NC * PES;

  logic [LIST_W-1:0] list;
  logic [7:0]        f_aff1, f_aff2, f_aff3;
  logic              mode;
  logic [3:0]        rs, rs_eff;
  logic              drop, cl_ok, bad;
  logic [NPE-1:0]    hit, allow;
  logic              unused_bits;

  assign list   = wdata_i[15:0];
  assign f_aff1 = wdata_i[23:16];
  assign f_aff2 = wdata_i[39:32];
  assign f_aff3 = wdata_i[55:48];
  assign mode   = wdata_i[40];
  assign rs     = wdata_i[47:44];
  assign unused_bits = ^{wdata_i[63:56], wdata_i[43:41], wdata_i[31:28], wdata_i[27:24]};

  assign rs_eff = rs_en_i ? rs : 4'd0;
  assign drop   = rs_en_i && !dist_rs_i && (rs != 4'd0);
  assign cl_ok  = (f_aff3 == 8'd0) && (f_aff2 == 8'd0) && (int'(f_aff1) < NC);

  for (genvar p = 0; p < NPE; p++) begin : g_pe
    localparam int A1 = p / PES;
    localparam int A0 = p % PES;
    logic is_self;
    assign is_self = (self_i.aff3 == 8'd0) && (self_i.aff2 == 8'd0) &&
                     (int'(self_i.aff1) == A1) && (int'(self_i.aff0) == A0);
    assign hit[p] = mode ? !is_self
                         : (cl_ok && (int'(f_aff1) == A1) &&
                            ((A0 / 16) == int'(rs_eff)) && list[A0 % 16]);
  end

  assign allow = (!secure_i && !sec_dis_i) ? ns_allow_i : '1;

  always_comb begin
    bad = 1'b0;
    for (int n = 0; n < LIST_W; n++) begin
      if (list[n] && !(cl_ok && ((int'(rs_eff) * 16 + n) < PES))) bad = 1'b1;
    end
  end

  assign mask_o = drop ? '0 : (hit & allow);
  assign bad_o  = bad && !mode && !drop;
endmodule

// File: rtl/sgi_pick.sv
module sgi_pick #(
  parameter int N = 8,
  parameter int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] vec_i,
  output logic [W-1:0] idx_o,
  output logic         any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = W'(i);
    end
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
  import sgi_pkg::*;
#(
  parameter int NC    = 2,
  parameter int PES   = 4,
  parameter int IDX_W = (NC * PES > 1) ? $clog2(NC * PES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic [63:0]          req_data_i,
  input  logic [31:0]          self_aff_i,
  input  logic                 secure_i,
  input  logic                 rs_en_i,
  input  logic                 dist_rs_i,
  input  logic                 sec_dis_i,
  input  logic [NC*PES-1:0]    ns_allow_i,
  output logic                 dlv_valid_o,
  input  logic                 dlv_ready_i,
  output logic [IDX_W-1:0]     dlv_target_o,
  output logic [INTID_W-1:0]   dlv_intid_o,
  output logic                 busy_o,
  output logic                 err_o
);
  localparam int NPE = NC * PES;

  logic [NPE-1:0]     dec_mask, pend_q;
  logic               dec_bad, any, accept, take;
  logic [IDX_W-1:0]   pick_idx;
  logic [INTID_W-1:0] intid_q;
  logic               err_q;

  sgi_decode #(.NC(NC), .PES(PES)) u_dec (
    .wdata_i    (req_data_i),
    .self_i     (aff_t'(self_aff_i)),
    .secure_i   (secure_i),
    .rs_en_i    (rs_en_i),
    .dist_rs_i  (dist_rs_i),
    .sec_dis_i  (sec_dis_i),
    .ns_allow_i (ns_allow_i),
    .mask_o     (dec_mask),
    .bad_o      (dec_bad)
  );

  sgi_pick #(.N(NPE), .W(IDX_W)) u_pick (
    .vec_i (pend_q),
    .idx_o (pick_idx),
    .any_o (any)
  );

  assign busy_o       = any;
  assign req_ready_o  = !any;
  assign dlv_valid_o  = any;
  assign dlv_target_o = pick_idx;
  assign dlv_intid_o  = intid_q;
  assign err_o        = err_q;
  assign accept       = req_valid_i && req_ready_o;
  assign take         = dlv_valid_o && dlv_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      intid_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= accept && dec_bad;
      if (accept) begin
        pend_q  <= dec_mask;
        intid_q <= req_data_i[INTID_LO +: INTID_W];
      end else if (take) begin
        pend_q[pick_idx] <= 1'b0;
      end
    end
  end

  AST_ERR_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_valid_i && req_ready_o)); // R4

  AST_ONE_PER_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> ($countones(pend_q) == $countones($past(pend_q)) - 1)); // R8

  AST_ASCENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> (!dlv_valid_o || (dlv_target_o > $past(dlv_target_o)))); // R8

  AST_HOLD_ON_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dlv_valid_o && !dlv_ready_i) |=>
      (dlv_valid_o && $stable(dlv_target_o) && $stable(dlv_intid_o))); // R8

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || $past(take))); // R9

  AST_PEND_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlv_valid_o |-> pend_q[dlv_target_o]); // R8
endmodule

// File: tb/sgi_dispatch_test.sv
module sgi_dispatch_test;
  localparam int NC = 2, PES = 4, NPE = NC * PES, IDX_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [63:0] req_data = '0;
  logic [31:0] self_aff = '0;
  logic secure = 1'b1, rs_en = 1'b0, dist_rs = 1'b0, sec_dis = 1'b0;
  logic [NPE-1:0] ns_allow = '0;
  logic dlv_valid, dlv_ready = 1'b0;
  logic [IDX_W-1:0] dlv_target;
  logic [3:0] dlv_intid;
  logic busy, err;

  int checks = 0, errors = 0, cyc = 0;
  int exp_q[$];

  always #10 clk = ~clk;

  sgi_dispatch #(.NC(NC), .PES(PES), .IDX_W(IDX_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_data_i(req_data), .self_aff_i(self_aff), .secure_i(secure), .rs_en_i(rs_en),
    .dist_rs_i(dist_rs), .sec_dis_i(sec_dis), .ns_allow_i(ns_allow),
    .dlv_valid_o(dlv_valid), .dlv_ready_i(dlv_ready), .dlv_target_o(dlv_target),
    .dlv_intid_o(dlv_intid), .busy_o(busy), .err_o(err));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: stalls every third cycle, pops and compares each delivery
  always @(negedge clk) begin
    cyc++;
    dlv_ready <= (cyc % 3 != 1);
    #1;
    if (rst_n && dlv_valid && dlv_ready) begin
      if (exp_q.size() == 0) begin
        check(0, "R6/R8 unexpected delivery", int'(dlv_target), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(int'(dlv_target) == e % 256, "R2/R3/R8 target", int'(dlv_target), e % 256);
        check(int'(dlv_intid) == e / 256, "R1 intid", int'(dlv_intid), e / 256);
      end
    end
  end

  task automatic write(input logic [63:0] d, input logic [31:0] me, input bit sec,
                       input bit rse, input bit drs, input bit sd,
                       input logic [NPE-1:0] allow, input string tag);
    bit [NPE-1:0] m = '0;
    bit bad = 0;
    int rs = rse ? int'(d[47:44]) : 0;
    bit ok_cl = (d[55:48] == 0) && (d[39:32] == 0) && (int'(d[23:16]) < NC);
    int cnt = 0;
    if (d[40]) begin
      for (int p = 0; p < NPE; p++)
        if (!(me[31:16] == 0 && int'(me[15:8]) == p / PES && int'(me[7:0]) == p % PES)) m[p] = 1;
    end else begin
      for (int n = 0; n < 16; n++) begin
        if (d[n]) begin
          if (ok_cl && rs * 16 + n < PES) m[int'(d[23:16]) * PES + rs * 16 + n] = 1;
          else bad = 1;
        end
      end
    end
    if (rse && !drs && d[47:44] != 0) begin m = '0; bad = 0; end
    if (!sec && !sd) m = m & allow;
    for (int p = 0; p < NPE; p++) if (m[p]) begin exp_q.push_back(int'(d[27:24]) * 256 + p); cnt++; end
    @(negedge clk);
    req_data = d; self_aff = me; secure = sec; rs_en = rse; dist_rs = drs;
    sec_dis = sd; ns_allow = allow; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    #2;
    check(err == bad, {tag, " R4 err"}, int'(err), int'(bad));
    check(busy == (cnt > 0), {tag, " R9 busy"}, int'(busy), int'(cnt > 0));
    check(req_ready == !busy, {tag, " R9 ready"}, int'(req_ready), int'(!busy));
    @(negedge clk);
    #2;
    check(err == 0, {tag, " R4 pulse width"}, int'(err), 0);
    while (busy) @(negedge clk);
    #3;
    check(exp_q.size() == 0, {tag, " R8 all delivered"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    check(0, "watchdog", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check(busy == 0 && dlv_valid == 0, "R9 reset busy", int'(busy), 0);
    check(req_ready == 1 && err == 0, "R9 reset ready", int'(req_ready), 1);
    rst_n = 1'b1;
    // R1 R2 targeted cluster 0, targets 0,1,3
    write(64'h0000_0000_0500_000B, 32'h0, 1, 0, 0, 0, '0, "t0");
    // R2 cluster 1
    write(64'h0000_0000_0901_0006, 32'h0, 1, 0, 0, 0, '0, "t1");
    // R4 invalid bits 4,5 plus valid bit 0
    write(64'h0000_0000_0301_0031, 32'h0, 1, 0, 0, 0, '0, "t2");
    // R4 nonexistent cluster
    write(64'h0000_0000_0203_0003, 32'h0, 1, 0, 0, 0, '0, "t3");
    // R3 broadcast except self (aff1=1, aff0=2), junk fields
    write(64'h0077_0155_0A33_FFFF, 32'h0000_0102, 1, 0, 0, 0, '0, "t4");
    // R5 RS ignored when unsupported
    write(64'h0000_5000_0400_0001, 32'h0, 1, 0, 0, 0, '0, "t5");
    // R6 write dropped
    write(64'h0000_2000_0600_000F, 32'h0, 1, 1, 0, 0, '0, "t6");
    // R2 RS=1 honoured -> aff0 16 absent
    write(64'h0000_1000_0700_0001, 32'h0, 1, 1, 1, 0, '0, "t7");
    // R7 non-secure filter
    write(64'h0000_0000_0800_000F, 32'h0, 0, 0, 0, 0, 8'b1010_0101, "t8");
    // R7 security disabled
    write(64'h0000_0000_0C00_000F, 32'h0, 0, 0, 0, 1, 8'b1010_0101, "t9");
    // R7 R3 non-secure broadcast
    write(64'h0000_0100_0D00_0000, 32'h0000_0000, 0, 0, 0, 0, 8'b0110_0011, "t10");
    // R7 secure ignores allow vector
    write(64'h0000_0000_0E01_0009, 32'h0, 1, 0, 0, 0, '0, "t11");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule